// File: doc/BRIEF.md
# Compare-capable GPIO output port

A parameterised general-purpose port, 16 lines by default, in which each line can serve as a timer compare output or a capture input. Per line, the block keeps four registers: an output latch, a direction bit, an open-drain bit and a synchronised input latch. A compare unit, outside this block, drives three per-line vectors:

- a compare-trigger strobe;
- a mode bit, which selects toggle or set/clear behaviour;
- a timer-overflow strobe.

On a trigger the port changes the output latch by the rule that the mode selects.

A CPU reaches all registers through a single-cycle synchronous bus with a 2-bit select. A CPU write to the output latch always takes precedence over a hardware update in the same cycle, so software can set the starting level of a toggling line at any time. The block drives an output value and an output enable per pad, and it returns per-line capture data to the compare unit.

Top module: `cmp_gpio_port`

## Requirements
- R1: After reset the output latch, direction and open-drain registers are all zero, and every pad output enable is 0.
- R2: Register select encoding: 0 = output latch, 1 = direction (1 = output), 2 = open-drain control (1 = open-drain), 3 = input latch. bus_rdata shows the selected register one clock after the select is presented, with the value the register held at that edge.
- R3: When a line's cmp_mode bit is 0 (toggle), an asserted cmp_trig bit inverts that line's output latch at the next edge. tmr_ovf has no effect in this mode.
- R4: When a line's cmp_mode bit is 1 (set/clear), an asserted cmp_trig bit writes 1 to the output latch if tmr_ovf for that line is 0. It writes 0 if tmr_ovf is 1.
- R5: Without its cmp_trig bit, a line's output latch changes only by a CPU write, and tmr_ovf alone does nothing.
- R6: A CPU write to the output latch (select 0) stores bus_wdata on every line, and any hardware update in the same cycle is discarded.
- R7: A line with direction 1 and open-drain 0 drives pad_oe = 1 and pad_out equal to its output latch.
- R8: A line with open-drain 1 drives pad_out = 0, and drives pad_oe = 1 only when direction is 1 and the latch is 0.
- R9: A line with direction 0 drives pad_oe = 0 regardless of any other setting.
- R10: cap_data for a line equals the output latch when direction is 1. When direction is 0 it equals the input latch, which follows pin_in through two flops: a pin change before edge k appears after edge k+1.
- R11: The input latch (select 3) is read-only. A write with select 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | LINES | Write data |
| bus_rdata | output | LINES | Registered read data |
| cmp_trig | input | LINES | Per-line compare-trigger strobe |
| cmp_mode | input | LINES | Per-line mode: 0 toggle, 1 set/clear |
| tmr_ovf | input | LINES | Per-line timer-overflow flag |
| pin_in | input | LINES | Pad input levels (asynchronous) |
| pad_out | output | LINES | Pad output value |
| pad_oe | output | LINES | Pad output enable |
| cap_data | output | LINES | Capture data to the compare unit |

## Verification
The latch update logic is swept with pseudo-random per-line vectors of trigger, mode and overflow. Every cycle therefore mixes all four line cases (toggle, set, clear, idle) across the 16 lines, which tells apart a mode decode error from a gating error on the trigger. These cycles are interleaved with writes to each select, including the read-only one. Writes to the output latch land in cycles with live triggers, which separates CPU priority from hardware update.

Direction and open-drain patterns change during the sweep, so pad checks cover all eight combinations of direction, open-drain and latch. A separate pin step shows the two-edge capture latency.

// File: rtl/cmp_gpio_pkg.sv
package cmp_gpio_pkg;

    typedef enum logic [1:0] {
        SEL_OUT = 2'd0,
        SEL_DIR = 2'd1,
        SEL_ODC = 2'd2,
        SEL_INP = 2'd3
    } sel_e;

    localparam logic MODE_TOGGLE = 1'b0;
    localparam logic MODE_SETCLR = 1'b1;

endpackage

// File: rtl/cmp_gpio_sync.sv
module cmp_gpio_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/cmp_gpio_next.sv
module cmp_gpio_next
    import cmp_gpio_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] out_q,
    input  logic [W-1:0] trig,
    input  logic [W-1:0] mode,
    input  logic [W-1:0] ovf,
    input  logic         cpu_wr,
    input  logic [W-1:0] cpu_data,
    output logic [W-1:0] out_d
);
    // Per-line next value of the output latch; CPU write has top priority.
    for (genvar i = 0; i < W; i++) begin : g_line
        logic hw_val;
        assign hw_val   = (mode[i] == MODE_TOGGLE) ? ~out_q[i] : ~ovf[i];
        assign out_d[i] = cpu_wr  ? cpu_data[i] :
                          trig[i] ? hw_val      : out_q[i];
    end
endmodule

// File: rtl/cmp_gpio_pad.sv
module cmp_gpio_pad #(
    parameter int W = 16
) (
    input  logic [W-1:0] out_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] odc_q,
    input  logic [W-1:0] in_q,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] cap_data
);
    for (genvar i = 0; i < W; i++) begin : g_pad
        always_comb begin
            if (odc_q[i]) begin
                pad_out[i] = 1'b0;
                pad_oe[i]  = dir_q[i] & ~out_q[i];
            end else begin
                pad_out[i] = out_q[i];
                pad_oe[i]  = dir_q[i];
            end
            cap_data[i] = dir_q[i] ? out_q[i] : in_q[i];
        end
    end
endmodule

// File: rtl/cmp_gpio_port.sv
module cmp_gpio_port
    import cmp_gpio_pkg::*;
#(
    parameter int LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_sel,
    input  logic [LINES-1:0] bus_wdata,
    output logic [LINES-1:0] bus_rdata,
    input  logic [LINES-1:0] cmp_trig,
    input  logic [LINES-1:0] cmp_mode,
    input  logic [LINES-1:0] tmr_ovf,
    input  logic [LINES-1:0] pin_in,
    output logic [LINES-1:0] pad_out,
    output logic [LINES-1:0] pad_oe,
    output logic [LINES-1:0] cap_data
);
    typedef struct packed {
        logic [LINES-1:0] outl;
        logic [LINES-1:0] dir;
        logic [LINES-1:0] odc;
        logic [LINES-1:0] rdata;
    } regs_t;

    regs_t            r_d, r_q;
    logic [LINES-1:0] in_q;
    logic [LINES-1:0] out_nxt;
    sel_e             sel;
    logic             wr_out;

    assign sel    = sel_e'(bus_sel);
    assign wr_out = bus_wr && (sel == SEL_OUT);

    cmp_gpio_sync #(.W(LINES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (in_q)
    );

    cmp_gpio_next #(.W(LINES)) u_next (
        .out_q    (r_q.outl),
        .trig     (cmp_trig),
        .mode     (cmp_mode),
        .ovf      (tmr_ovf),
        .cpu_wr   (wr_out),
        .cpu_data (bus_wdata),
        .out_d    (out_nxt)
    );

    cmp_gpio_pad #(.W(LINES)) u_pad (
        .out_q    (r_q.outl),
        .dir_q    (r_q.dir),
        .odc_q    (r_q.odc),
        .in_q     (in_q),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .cap_data (cap_data)
    );

    always_comb begin
        r_d      = r_q;
        r_d.outl = out_nxt;
        if (bus_wr) begin
            case (sel)
                SEL_DIR: r_d.dir = bus_wdata;
                SEL_ODC: r_d.odc = bus_wdata;
                default: ;  // output latch handled in u_next; input latch read-only
            endcase
        end
        case (sel)
            SEL_OUT: r_d.rdata = r_q.outl;
            SEL_DIR: r_d.rdata = r_q.dir;
            SEL_ODC: r_d.rdata = r_q.odc;
            default: r_d.rdata = in_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata = r_q.rdata;

    // ---------------- assertions ----------------
    AST_CPU_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_out |=> r_q.outl == $past(bus_wdata))
        else $error("cpu write lost"); // R6

    AST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_out |=> ((r_q.outl ^ $past(r_q.outl)) & $past(cmp_trig & ~cmp_mode))
                    == $past(cmp_trig & ~cmp_mode))
        else $error("toggle missed"); // R3

    AST_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_out |=> (r_q.outl & $past(cmp_trig & cmp_mode & ~tmr_ovf))
                    == $past(cmp_trig & cmp_mode & ~tmr_ovf))
        else $error("set missed"); // R4

    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_out |=> (r_q.outl & $past(cmp_trig & cmp_mode & tmr_ovf)) == '0)
        else $error("clear missed"); // R4

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_out |=> ((r_q.outl ^ $past(r_q.outl)) & ~$past(cmp_trig)) == '0)
        else $error("latch changed without trigger"); // R5

    AST_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~r_q.dir) == '0)
        else $error("enable on input line"); // R9

    AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & r_q.odc) == '0) && ((pad_oe & r_q.odc & r_q.outl) == '0))
        else $error("open-drain drove high"); // R8

    AST_INP_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_INP) |=> $stable(r_q.dir) && $stable(r_q.odc))
        else $error("read-only write took effect"); // R11
endmodule

// File: tb/cmp_gpio_port_test.sv
module cmp_gpio_port_test;
    localparam int L = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_sel = 2'd0;
    logic [L-1:0] bus_wdata = '0;
    logic [L-1:0] bus_rdata;
    logic [L-1:0] cmp_trig = '0, cmp_mode = '0, tmr_ovf = '0, pin_in = '0;
    logic [L-1:0] pad_out, pad_oe, cap_data;

    int errs = 0;
    int checks = 0;

    logic [L-1:0] m_out = '0, m_dir = '0, m_odc = '0, m_pin = '0;

    always #5 clk = ~clk;

    cmp_gpio_port #(.LINES(L)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_trig(cmp_trig),
        .cmp_mode(cmp_mode), .tmr_ovf(tmr_ovf), .pin_in(pin_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .cap_data(cap_data)
    );

    task automatic check(input string tag, input logic [L-1:0] act, input logic [L-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [L-1:0] mix(input int a, input int b);
        logic [31:0] x;
        x = 32'(a) * 32'h9E3779B1 + 32'(b) * 32'h85EBCA6B + 32'h1234567;
        x = x ^ (x >> 15);
        x = x * 32'h2C1B3C6D;
        x = x ^ (x >> 12);
        return x[L-1:0];
    endfunction

    // One clock with the given stimulus; model updated per requirements.
    task automatic step(input logic wr, input logic [1:0] sel, input logic [L-1:0] wd,
                        input logic [L-1:0] tr, input logic [L-1:0] md, input logic [L-1:0] ov);
        bus_wr = wr; bus_sel = sel; bus_wdata = wd;
        cmp_trig = tr; cmp_mode = md; tmr_ovf = ov;
        @(posedge clk);
        @(negedge clk);
        if (wr && sel == 2'd0) m_out = wd;                                  // R6
        else m_out = (tr & ~md & ~m_out) | (tr & md & ~ov) | (~tr & m_out); // R3 R4 R5
        if (wr && sel == 2'd1) m_dir = wd;
        if (wr && sel == 2'd2) m_odc = wd;
        bus_wr = 1'b0; cmp_trig = '0; cmp_mode = '0; tmr_ovf = '0;
    endtask

    task automatic check_pads(input string note);
        check({"R7 R8 R9 pad_oe ", note}, pad_oe, m_dir & (~m_odc | ~m_out));
        check({"R7 R8 pad_out ", note}, pad_out, m_out & ~m_odc);
        check({"R10 cap_data ", note}, cap_data, (m_dir & m_out) | (~m_dir & m_pin));
    endtask

    task automatic read_chk(input logic [1:0] sel, input string tag);
        logic [L-1:0] exp;
        case (sel)
            2'd0: exp = m_out;
            2'd1: exp = m_dir;
            2'd2: exp = m_odc;
            default: exp = m_pin;
        endcase
        bus_sel = sel; bus_wr = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(tag, bus_rdata, exp);
    endtask

    initial begin
        #1000000;
        errs++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 pad_oe at reset", pad_oe, '0);
        rst_n = 1'b1;
        @(negedge clk);
        read_chk(2'd0, "R1 R2 out latch reset");
        read_chk(2'd1, "R1 R2 dir reset");
        read_chk(2'd2, "R1 R2 odc reset");

        // R10: two-edge input latency
        pin_in = 16'hA5C3;
        @(posedge clk); @(negedge clk);
        check("R10 cap after one edge", cap_data, 16'h0000);
        @(posedge clk); @(negedge clk);
        m_pin = 16'hA5C3;
        check("R10 cap after two edges", cap_data, 16'hA5C3);
        read_chk(2'd3, "R2 R11 input latch read");

        // R6: write wins against all-line toggle and set triggers
        step(1'b1, 2'd0, 16'h00FF, 16'hFFFF, 16'hF0F0, 16'h0000);
        read_chk(2'd0, "R6 cpu over trigger");

        // R5: overflow alone does nothing
        step(1'b0, 2'd0, '0, 16'h0000, 16'hFFFF, 16'hFFFF);
        read_chk(2'd0, "R5 ovf without trigger");

        // R3 / R4 directed
        step(1'b0, 2'd0, '0, 16'h000F, 16'h0000, 16'h0005);
        read_chk(2'd0, "R3 toggle ignores ovf");
        step(1'b0, 2'd0, '0, 16'hFF00, 16'hFF00, 16'hF000);
        read_chk(2'd0, "R4 set and clear");

        // Sweep
        for (int it = 0; it < 96; it++) begin
            logic [1:0] ws;
            ws = 2'(it % 4);
            step((it % 3) != 2, ws, mix(it, 4), mix(it, 1), mix(it, 2), mix(it, 3));
            check_pads("sweep");
            read_chk(2'(it % 4), "R2 R3 R4 R5 R6 R11 sweep readback");
        end

        // R11: write to select 3 changes nothing
        step(1'b1, 2'd3, 16'h5A5A, '0, '0, '0);
        read_chk(2'd0, "R11 out after ro write");
        read_chk(2'd1, "R11 dir after ro write");
        read_chk(2'd2, "R11 odc after ro write");
        read_chk(2'd3, "R11 input latch after ro write");

        // Pad corner combinations, explicit
        step(1'b1, 2'd1, 16'h0F0F, '0, '0, '0);
        step(1'b1, 2'd2, 16'h3333, '0, '0, '0);
        step(1'b1, 2'd0, 16'h5555, '0, '0, '0);
        check_pads("all eight combos");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule